// File: doc/BRIEF.md
# Shared-pin video memory access sequencer

This block turns single-byte register-port requests into accesses on a video-memory bus whose low address bits and data share one set of pins. A request carries a direction bit, a full address and, for a write, a data byte. Once accepted, the request waits until the sequencer lines up with a free-running half-pixel tick. It then runs a fixed pattern on the shared pins: an address-latch phase, a short quiet gap and a strobe phase. The pattern is the same every time, and no rendering activity can delay or reorder it.

The master clock drives everything. A divider produces a tick every `HALF_CLKS` master clocks, so one pixel spans two ticks. Every phase length is a whole number of ticks. When a request is accepted, the start of the address phase therefore depends on where the divider stands at that moment. A read samples the returned byte at the end of its strobe and keeps it in a read buffer. A single pending slot holds one request while another is on the bus.

The request side uses valid/ready. `req_valid` must stay high, and the payload must not change, until a clock edge at which `req_ready` is high. `req_ready` is high exactly when the pending slot is empty. The read result has no back-pressure. `rd_valid` pulses for one clock and `rd_data` holds the byte until the next read completes.

Top module: `vram_seq`

## Requirements
- R1: After reset `ale`=0, `wr_n`=1, `rd_n`=1, `vbus_oe`=0, `busy`=0, `req_ready`=1, `rd_valid`=0 and `rd_data`=0.
- R2: Each access starts with `ale` high for exactly 4 master clocks (two ticks). During those clocks `vbus_out` carries address bits [7:0], `vaddr_hi` carries address bits [13:8] and `vbus_oe`=1.
- R3: After `ale` falls there are exactly 2 master clocks (one tick) in which `ale`=0, `wr_n`=1 and `rd_n`=1.
- R4: For a write (`req_write`=1), `wr_n` is low for exactly 4 master clocks. During that time `vbus_out` carries the request's data byte, `vbus_oe`=1 and `vaddr_hi` holds the upper address bits.
- R5: For a read (`req_write`=0), `rd_n` is low for exactly 4 master clocks with `vbus_oe`=0. The byte on `vbus_in` in the last strobe clock appears on `rd_data`, with `rd_valid` high for one clock, in the clock in which `rd_n` returns high.
- R6: A request accepted while the block is idle raises `ale` 4 or 5 master clocks after the accepting edge, depending on the tick phase. The whole access finishes within 44 master clocks.
- R7: One request can wait in the pending slot while another runs. `req_ready` is low while the slot is full, and `busy` is high while an access runs or the slot is full. Accepted requests execute in acceptance order and none is lost.
- R8: A write never pulses `rd_valid` and leaves `rd_data` unchanged.
- R9: `wr_n` and `rd_n` are never low together, and neither is low while `ale` is high. `vbus_oe` is high only during the address phase and the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Pending slot free; request taken at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Full memory address |
| req_data | input | 8 | Write data byte |
| busy | output | 1 | Access running or request pending |
| rd_valid | output | 1 | One-clock pulse: read byte available |
| rd_data | output | 8 | Read buffer |
| vbus_out | output | 8 | Shared address/data pins, driven value |
| vbus_in | input | 8 | Shared pins, value returned by memory |
| vbus_oe | output | 1 | Output enable of the shared pins |
| vaddr_hi | output | 6 | Upper address pins |
| ale | output | 1 | Address latch enable, active high |
| wr_n | output | 1 | Write strobe, active low |
| rd_n | output | 1 | Read strobe, active low |

## Verification
The bench uses the default parameters: a tick every 2 master clocks, a sync wait of two ticks, and phases of 2, 1 and 2 ticks. Every access therefore fits in about 15 clocks. Shifting the idle spacing between requests by one clock moves the acceptance across both divider phases, which makes both start latencies of R6 appear. Firing three requests back to back fills the single slot, so the stall of R7 and the in-order replay both occur.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SYNC,
    PH_ALE,
    PH_GAP,
    PH_STB
  } vseq_phase_e;
endpackage

// File: rtl/vseq_pixdiv.sv
module vseq_pixdiv #(
  parameter int HALF_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic hp_tick
);
  localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  logic [CW-1:0] cnt_q;

  assign hp_tick = (cnt_q == CW'(HALF_CLKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (hp_tick) cnt_q <= '0;
    else              cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/vseq_reqslot.sv
module vseq_reqslot #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_write,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic              take,
  output logic              slot_valid,
  output logic              slot_write,
  output logic [ADDR_W-1:0] slot_addr,
  output logic [DATA_W-1:0] slot_data
);
  assign in_ready = !slot_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_valid <= 1'b0;
      slot_write <= 1'b0;
      slot_addr  <= '0;
      slot_data  <= '0;
    end else if (take) begin
      slot_valid <= 1'b0;
    end else if (in_valid && in_ready) begin
      slot_valid <= 1'b1;
      slot_write <= in_write;
      slot_addr  <= in_addr;
      slot_data  <= in_data;
    end
  end
endmodule

// File: rtl/vseq_phase_fsm.sv
module vseq_phase_fsm
  import vseq_pkg::*;
#(
  parameter int SYNC_HP = 2,
  parameter int ALE_HP  = 2,
  parameter int GAP_HP  = 1,
  parameter int STB_HP  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hp_tick,
  input  logic        start,
  output vseq_phase_e phase,
  output logic        idle,
  output logic        seq_end
);
  localparam int M1     = (SYNC_HP > ALE_HP) ? SYNC_HP : ALE_HP;
  localparam int M2     = (GAP_HP > STB_HP) ? GAP_HP : STB_HP;
  localparam int MAXLEN = (M1 > M2) ? M1 : M2;
  localparam int CW     = $clog2(MAXLEN + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cur_len;
  logic          last;
  vseq_phase_e   nxt;

  always_comb begin
    cur_len = CW'(1);
    nxt     = PH_IDLE;
    case (phase)
      PH_SYNC: begin cur_len = CW'(SYNC_HP); nxt = PH_ALE;  end
      PH_ALE:  begin cur_len = CW'(ALE_HP);  nxt = PH_GAP;  end
      PH_GAP:  begin cur_len = CW'(GAP_HP);  nxt = PH_STB;  end
      PH_STB:  begin cur_len = CW'(STB_HP);  nxt = PH_IDLE; end
      default: begin cur_len = CW'(1);       nxt = PH_IDLE; end
    endcase
  end

  assign last    = (cnt_q == (cur_len - CW'(1)));
  assign idle    = (phase == PH_IDLE);
  assign seq_end = (phase == PH_STB) && hp_tick && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt_q <= '0;
    end else if (phase == PH_IDLE) begin
      cnt_q <= '0;
      if (start) phase <= PH_SYNC;
    end else if (hp_tick) begin
      if (last) begin
        phase <= nxt;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/vseq_busdrv.sv
module vseq_busdrv
  import vseq_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     in_write,
  input  logic [ADDR_W-1:0]        in_addr,
  input  logic [DATA_W-1:0]        in_data,
  input  vseq_phase_e              phase,
  input  logic                     seq_end,
  input  logic [DATA_W-1:0]        bus_in,
  output logic [DATA_W-1:0]        bus_out,
  output logic                     bus_oe,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic                     ale,
  output logic                     wr_n,
  output logic                     rd_n,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        rd_data
);
  logic              op_wr_q;
  logic [ADDR_W-1:0] op_addr_q;
  logic [DATA_W-1:0] op_data_q;
  logic              in_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_wr_q   <= 1'b0;
      op_addr_q <= '0;
      op_data_q <= '0;
    end else if (start) begin
      op_wr_q   <= in_write;
      op_addr_q <= in_addr;
      op_data_q <= in_data;
    end
  end

  assign in_stb  = (phase == PH_STB);
  assign ale     = (phase == PH_ALE);
  assign wr_n    = !(in_stb && op_wr_q);
  assign rd_n    = !(in_stb && !op_wr_q);
  assign bus_oe  = ale || (in_stb && op_wr_q);
  assign addr_hi = op_addr_q[ADDR_W-1:DATA_W];

  always_comb begin
    if (ale)                    bus_out = op_addr_q[DATA_W-1:0];
    else if (in_stb && op_wr_q) bus_out = op_data_q;
    else                        bus_out = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= seq_end && !op_wr_q;
      if (seq_end && !op_wr_q) rd_data <= bus_in;
    end
  end
endmodule

// File: rtl/vram_seq.sv
module vram_seq
  import vseq_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int DATA_W    = 8,
  parameter int HALF_CLKS = 2,
  parameter int SYNC_HP   = 2,
  parameter int ALE_HP    = 2,
  parameter int GAP_HP    = 1,
  parameter int STB_HP    = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_data,
  output logic                     busy,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        rd_data,
  output logic [DATA_W-1:0]        vbus_out,
  input  logic [DATA_W-1:0]        vbus_in,
  output logic                     vbus_oe,
  output logic [ADDR_W-DATA_W-1:0] vaddr_hi,
  output logic                     ale,
  output logic                     wr_n,
  output logic                     rd_n
);
  logic              hp_tick;
  logic              slot_valid, slot_write;
  logic [ADDR_W-1:0] slot_addr;
  logic [DATA_W-1:0] slot_data;
  logic              start, fsm_idle, seq_end;
  vseq_phase_e       phase;

  assign start = slot_valid && fsm_idle;
  assign busy  = slot_valid || !fsm_idle;

  vseq_pixdiv #(.HALF_CLKS(HALF_CLKS)) u_div (
    .clk(clk), .rst_n(rst_n), .hp_tick(hp_tick)
  );

  vseq_reqslot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slot (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready), .in_write(req_write),
    .in_addr(req_addr), .in_data(req_data), .take(start),
    .slot_valid(slot_valid), .slot_write(slot_write),
    .slot_addr(slot_addr), .slot_data(slot_data)
  );

  vseq_phase_fsm #(
    .SYNC_HP(SYNC_HP), .ALE_HP(ALE_HP), .GAP_HP(GAP_HP), .STB_HP(STB_HP)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .hp_tick(hp_tick), .start(start),
    .phase(phase), .idle(fsm_idle), .seq_end(seq_end)
  );

  vseq_busdrv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .start(start),
    .in_write(slot_write), .in_addr(slot_addr), .in_data(slot_data),
    .phase(phase), .seq_end(seq_end), .bus_in(vbus_in),
    .bus_out(vbus_out), .bus_oe(vbus_oe), .addr_hi(vaddr_hi),
    .ale(ale), .wr_n(wr_n), .rd_n(rd_n),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/vram_seq_chk.sv
module vram_seq_chk #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8,
  parameter int LIMIT  = 44
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_ready,
  input logic                     busy,
  input logic                     rd_valid,
  input logic [DATA_W-1:0]        vbus_out,
  input logic                     vbus_oe,
  input logic [ADDR_W-DATA_W-1:0] vaddr_hi,
  input logic                     ale,
  input logic                     wr_n,
  input logic                     rd_n
);
  logic        run_q;
  logic        ale_q;
  logic [15:0] tmr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ale_q <= 1'b0;
      tmr_q <= '0;
    end else begin
      ale_q <= ale;
      if (ale && !ale_q) begin
        run_q <= 1'b1;
        tmr_q <= 16'd1;
      end else if (run_q && wr_n && rd_n && !ale && tmr_q > 16'd3 &&
                   $past(!wr_n || !rd_n)) begin
        run_q <= 1'b0;
      end else if (run_q) begin
        tmr_q <= tmr_q + 16'd1;
      end
    end
  end

  a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!wr_n && !rd_n));
  a_r9_ale_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (wr_n && rd_n));
  a_r5_read_released: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !vbus_oe);
  a_r3_gap_after_ale: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> (wr_n && rd_n));
  a_r4_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && $past(!wr_n)) |-> ($stable(vbus_out) && $stable(vaddr_hi)));
  a_r7_stall_means_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> busy);
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  a_r6_within_window: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (tmr_q <= 16'(LIMIT)));
endmodule

bind vram_seq vram_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .busy(busy),
  .rd_valid(rd_valid), .vbus_out(vbus_out), .vbus_oe(vbus_oe),
  .vaddr_hi(vaddr_hi), .ale(ale), .wr_n(wr_n), .rd_n(rd_n)
);

// File: tb/vram_seq_bench.sv
module vram_seq_bench;
  localparam int AW = 14;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          req_ready, busy, rd_valid, vbus_oe, ale, wr_n, rd_n;
  logic [DW-1:0] rd_data, vbus_out, vbus_in;
  logic [AW-DW-1:0] vaddr_hi;

  always #5 clk = ~clk;

  vram_seq u_vram_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_data(req_data),
    .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
    .vbus_out(vbus_out), .vbus_in(vbus_in), .vbus_oe(vbus_oe),
    .vaddr_hi(vaddr_hi), .ale(ale), .wr_n(wr_n), .rd_n(rd_n)
  );

  function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
    return a[7:0] ^ {2'b00, a[13:8]} ^ 8'h5A;
  endfunction

  logic [AW-1:0] lat_addr = '0;
  assign vbus_in = rd_n ? 8'h00 : mem_val(lat_addr);

  typedef struct {
    bit            wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    int            acc;
    bit            lat;
  } item_t;
  item_t sb[$];

  int total = 0, bad = 0, cyc = 0;
  int seen4 = 0, seen5 = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic send(input bit wr, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input bit lat);
    item_t it;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_data = d;
    while (!req_ready) @(negedge clk);
    it.wr = wr; it.addr = a; it.data = d; it.acc = cyc + 1; it.lat = lat;
    sb.push_back(it);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor state
  bit            p_ale = 0, p_wr_n = 1, p_rd_n = 1, in_gap = 0;
  int            ale_len = 0, gap_len = 0, stb_len = 0;
  logic [AW-1:0] seen_addr = '0;
  logic [DW-1:0] wd = '0, last_rd = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit rv_now;
      bit stb;
      rv_now = 0;
      stb = !wr_n || !rd_n;
      // R9 pin rules
      if (!wr_n && !rd_n) chk(0, "R9 strobes both low", 1, 0);
      if (ale && stb) chk(0, "R9 ale with strobe", 1, 0);
      if (vbus_oe != (ale || !wr_n)) chk(0, "R9 oe window", vbus_oe, ale || !wr_n);
      // address phase
      if (ale) begin
        lat_addr = {vaddr_hi, vbus_out};
        if (!p_ale) begin
          seen_addr = {vaddr_hi, vbus_out};
          ale_len = 0;
          if (sb.size() == 0) chk(0, "R7 unexpected access", 1, 0);
          else if (sb[0].lat) begin
            chk((cyc - sb[0].acc) == 4 || (cyc - sb[0].acc) == 5,
                "R6 start latency", cyc - sb[0].acc, 4);
            if (cyc - sb[0].acc == 4) seen4++;
            if (cyc - sb[0].acc == 5) seen5++;
          end
        end
        ale_len++;
      end else if (p_ale) begin
        chk(ale_len == 4, "R2 ale length", ale_len, 4);
        if (sb.size() != 0) chk(seen_addr == sb[0].addr, "R2 address", seen_addr, sb[0].addr);
        in_gap = 1; gap_len = 0;
      end
      if (in_gap) begin
        if (!stb) gap_len++;
        else begin
          chk(gap_len == 2, "R3 gap length", gap_len, 2);
          in_gap = 0; stb_len = 0;
        end
      end
      if (stb) begin
        stb_len++;
        if (!wr_n) begin
          wd = vbus_out;
          if (sb.size() != 0) chk(vaddr_hi == sb[0].addr[13:8], "R4 upper address", vaddr_hi, sb[0].addr[13:8]);
        end
      end else if (!p_wr_n || !p_rd_n) begin
        if (sb.size() != 0) begin
          item_t h;
          h = sb.pop_front();
          if (h.wr) begin
            chk(!p_wr_n, "R4 strobe kind", p_wr_n, 0);
            chk(stb_len == 4, "R4 write strobe length", stb_len, 4);
            chk(wd == h.data, "R4 write data", wd, h.data);
          end else begin
            chk(!p_rd_n, "R5 strobe kind", p_rd_n, 0);
            chk(stb_len == 4, "R5 read strobe length", stb_len, 4);
            chk(rd_valid == 1'b1, "R5 rd_valid", rd_valid, 1);
            chk(rd_data == mem_val(h.addr), "R5 read data", rd_data, mem_val(h.addr));
            last_rd = mem_val(h.addr);
            rv_now = 1;
          end
        end
      end
      if (!rv_now) begin
        if (rd_valid) chk(0, "R8 stray rd_valid", 1, 0);
        if (rd_data != last_rd) chk(0, "R8 rd_data held", rd_data, last_rd);
      end
      p_ale = ale; p_wr_n = wr_n; p_rd_n = rd_n;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic drain();
    int n;
    n = 0;
    do begin @(negedge clk); n++; end while ((busy || sb.size() != 0) && n < 200);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!ale && wr_n && rd_n && !vbus_oe, "R1 bus pins idle", {ale, wr_n, rd_n, vbus_oe}, 4'b0110);
    chk(!busy && req_ready, "R1 ready/busy", {busy, req_ready}, 2'b01);
    chk(!rd_valid && rd_data == 8'h00, "R1 read buffer", rd_data, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && req_ready, "R1 after release", {busy, req_ready}, 2'b01);

    // R2 R4 R6: writes with varied spacing to hit both tick phases
    for (int i = 0; i < 6; i++) begin
      send(1'b1, 14'(14'h2100 + i * 33), 8'(8'hA0 + i * 7), 1'b1);
      drain();
      repeat (i) @(negedge clk);
    end
    // R5: reads, R8: read buffer holds across writes
    for (int i = 0; i < 6; i++) begin
      send(1'b0, 14'(14'h3F00 + i * 97), 8'h00, 1'b1);
      drain();
      repeat (i) @(negedge clk);
      send(1'b1, 14'(14'h0005 + i), 8'(8'h11 * i), 1'b1);
      drain();
    end
    // boundary addresses
    send(1'b1, 14'h3FFF, 8'hFF, 1'b1); drain();
    send(1'b0, 14'h0000, 8'h00, 1'b1); drain();

    // R7: three back to back, slot fills and stalls
    send(1'b1, 14'h1234, 8'h5C, 1'b0);
    send(1'b0, 14'h2345, 8'h00, 1'b0);
    chk(!req_ready && busy, "R7 slot full stalls", {req_ready, busy}, 2'b01);
    send(1'b1, 14'h0ABC, 8'hC3, 1'b0);
    drain();
    chk(sb.size() == 0, "R7 all executed", sb.size(), 0);
    chk(!busy && req_ready, "R7 idle after drain", {busy, req_ready}, 2'b01);
    chk(seen4 > 0 && seen5 > 0, "R6 both phases seen", seen4 * 100 + seen5, 101);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule